// File: doc/BRIEF.md
# Ones-Complement Accumulator with Store-and-Test

This block is a datapath slice that holds a 16-bit ones-complement accumulator. The top bit serves as an overflow guard, so the accumulator carries one bit more than a 15-bit memory word. Every operation arrives in one cycle with a 2-bit operation code and a 16-bit memory word. The word's top bit is an odd-parity bit, and its low 15 bits are a ones-complement number. The block can load the accumulator, add to it with end-around carry, or negate it by inverting every bit. Plus zero and minus zero stay distinct throughout.

The store-and-test operation always emits a memory write of a 15-bit value with hardware-generated odd parity. If the accumulator holds an overflow at that moment, the accumulator is replaced by plus one or minus one, matching the direction of the overflow. The block also raises a one-cycle skip request, which tells the sequencer to skip the next instruction. A parity error on any incoming operand word latches a sticky error output. Instruction fetch and the memory array are outside the block.

Top module: `oc_acc_unit`

## Requirements
- R1: After synchronous reset the accumulator is plus zero (0x0000), and wr_en, skip, par_err and ovf are all 0.
- R2: Operation code 0 (load) sets the accumulator to the 15 data bits of mem_rdata, extended by copying data bit 14 into accumulator bit 15.
- R3: Operation code 1 (add) adds the sign-extended operand to the accumulator. Any carry out of bit 15 is added back into bit 0 (end-around carry).
- R4: Operation code 2 (negate) inverts all 16 accumulator bits, so plus zero becomes minus zero (0xFFFF) and back.
- R5: is_pzero is 1 exactly when the accumulator is 0x0000, and is_mzero is 1 exactly when it is 0xFFFF.
- R6: ovf is 1 exactly when accumulator bits 15 and 14 differ. Bit 15 = 0 marks positive overflow, and bit 15 = 1 marks negative overflow.
- R7: Operation code 3 (store) always gives a one-cycle wr_en pulse. wr_word[14] is accumulator bit 15, wr_word[13:0] are accumulator bits 13:0, and wr_word[15] makes the 16-bit word have odd parity.
- R8: A store with positive overflow sets the accumulator to 0x0001, and one with negative overflow sets it to 0xFFFE. Either case also pulses skip for one cycle.
- R9: A store without overflow leaves the accumulator unchanged and leaves skip at 0.
- R10: par_err is set when a load or add arrives with a mem_rdata word of even parity, and it stays set until reset. The parity of mem_rdata is ignored for negate and store.
- R11: A cycle with op_valid low leaves the accumulator unchanged, and wr_en and skip are 0 after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 2 | 0 load, 1 add, 2 negate, 3 store |
| mem_rdata | input | 16 | Operand word: [15] odd parity, [14:0] data |
| acc | output | 16 | Accumulator, [15] overflow guard bit |
| ovf | output | 1 | Accumulator holds an overflow |
| is_pzero | output | 1 | Accumulator is plus zero |
| is_mzero | output | 1 | Accumulator is minus zero |
| wr_en | output | 1 | Store write strobe |
| wr_word | output | 16 | Word to memory: [15] odd parity, [14:0] data |
| skip | output | 1 | Request to skip the next instruction |
| par_err | output | 1 | Sticky operand parity error |

## Verification
The bench targets the zeros: 1 plus -1 must give minus zero, and minus zero plus minus zero must stay minus zero. An adder that drops the end-around carry gives 0x0001 instead of 0x0002 for 5 plus -3, and one that folds the two zeros together misreports the zero flags. Both overflow directions are driven through a store. A design that takes the stored sign from bit 14, or restores the wrong constant, writes a wrong word, leaves a wrong accumulator, or misses the skip. Parity is checked with words whose bit count is both odd and even, and the bench confirms that a bad word sent with negate or store does not set the error flag.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_ADD   = 2'd1,
    OP_NEG   = 2'd2,
    OP_STORE = 2'd3
  } acc_op_e;
endpackage

// File: rtl/oc_eac_adder.sv
// Ones-complement adder: carry out of the top bit re-enters at bit 0.
module oc_eac_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);
  logic [W:0] raw;
  always_comb begin
    raw = {1'b0, a} + {1'b0, b};
    sum = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
  end
endmodule

// File: rtl/oc_odd_par.sv
// Odd-parity bit generator: data plus returned bit has an odd number of ones.
module oc_odd_par #(
  parameter int W = 15
) (
  input  logic [W-1:0] data,
  output logic         par
);
  assign par = ~(^data);
endmodule

// File: rtl/oc_ovf_fix.sv
// Overflow detection and saturation-to-unit value for the guarded accumulator.
module oc_ovf_fix #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] acc_in,
  output logic          ovf,
  output logic [AW-1:0] fixed
);
  localparam logic [AW-1:0] PLUS_ONE = AW'(1);
  always_comb begin
    ovf   = acc_in[AW-1] ^ acc_in[AW-2];
    fixed = acc_in[AW-1] ? ~PLUS_ONE : PLUS_ONE;
  end
endmodule

// File: rtl/oc_acc_unit.sv
module oc_acc_unit #(
  parameter int DW = 15
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            op_valid,
  input  logic [1:0]      op_code,
  input  logic [DW:0]     mem_rdata,
  output logic [DW:0]     acc,
  output logic            ovf,
  output logic            is_pzero,
  output logic            is_mzero,
  output logic            wr_en,
  output logic [DW:0]     wr_word,
  output logic            skip,
  output logic            par_err
);
  import oc_pkg::*;
  localparam int AW = DW + 1;

  acc_op_e       op;
  logic [AW-1:0] operand_ext;
  logic [AW-1:0] add_sum;
  logic [AW-1:0] fix_val;
  logic [DW-1:0] store_data;
  logic          store_par;
  logic          rd_par;
  logic          par_bad;

  assign op          = acc_op_e'(op_code);
  assign operand_ext = {mem_rdata[DW-1], mem_rdata[DW-1:0]};
  assign store_data  = {acc[AW-1], acc[DW-2:0]};

  oc_eac_adder #(.W(AW)) u_add (.a(acc), .b(operand_ext), .sum(add_sum));
  oc_ovf_fix   #(.AW(AW)) u_fix (.acc_in(acc), .ovf(ovf), .fixed(fix_val));
  oc_odd_par   #(.W(DW)) u_par_wr (.data(store_data), .par(store_par));
  oc_odd_par   #(.W(DW)) u_par_rd (.data(mem_rdata[DW-1:0]), .par(rd_par));

  assign par_bad  = op_valid && (op == OP_LOAD || op == OP_ADD) && (rd_par != mem_rdata[DW]);
  assign is_pzero = (acc == '0);
  assign is_mzero = (acc == '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      wr_en   <= 1'b0;
      wr_word <= '0;
      skip    <= 1'b0;
      par_err <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      skip  <= 1'b0;
      if (par_bad) par_err <= 1'b1;
      if (op_valid) begin
        case (op)
          OP_LOAD: acc <= operand_ext;
          OP_ADD:  acc <= add_sum;
          OP_NEG:  acc <= ~acc;
          OP_STORE: begin
            wr_en   <= 1'b1;
            wr_word <= {store_par, store_data};
            if (ovf) begin
              acc  <= fix_val;
              skip <= 1'b1;
            end
          end
          default: acc <= acc;
        endcase
      end
    end
  end
endmodule

// File: rtl/oc_acc_unit_chk.sv
module oc_acc_unit_chk #(
  parameter int DW = 15
) (
  input logic        clk,
  input logic        rst,
  input logic        op_valid,
  input logic [1:0]  op_code,
  input logic [DW:0] acc,
  input logic        wr_en,
  input logic [DW:0] wr_word,
  input logic        skip,
  input logic        par_err
);
  localparam int AW = DW + 1;
  localparam logic [AW-1:0] P1 = AW'(1);

  a_r4_negate: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 2'd2) |=> acc == ~$past(acc));
  a_r7_store_writes: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 2'd3) |=> wr_en);
  a_r7_odd_parity: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ($countones(wr_word) % 2) == 1);
  a_r8_ovf_restore: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 2'd3 && acc[AW-1] != acc[AW-2]) |=> skip && (acc == P1 || acc == ~P1));
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 2'd3 && acc[AW-1] == acc[AW-2]) |=> !skip && $stable(acc));
  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    par_err |=> par_err);
  a_r11_idle: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> !wr_en && !skip && $stable(acc));
endmodule

bind oc_acc_unit oc_acc_unit_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .acc(acc),
  .wr_en(wr_en), .wr_word(wr_word), .skip(skip), .par_err(par_err)
);

// File: tb/oc_acc_unit_tb.sv
`timescale 1ns/1ps
module oc_acc_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic [1:0]  op_code;
  logic [15:0] mem_rdata;
  logic [15:0] acc, wr_word;
  logic        ovf, is_pzero, is_mzero, wr_en, skip, par_err;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  oc_acc_unit #(.DW(15)) u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .mem_rdata(mem_rdata),
    .acc(acc), .ovf(ovf), .is_pzero(is_pzero), .is_mzero(is_mzero),
    .wr_en(wr_en), .wr_word(wr_word), .skip(skip), .par_err(par_err)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one operation on a negedge; return at the following negedge.
  task automatic run_op(input logic [1:0] op, input logic [14:0] d, input bit bad = 0);
    @(negedge clk);
    op_valid  = 1'b1;
    op_code   = op;
    mem_rdata = {(~(^d)) ^ bad, d};
    @(negedge clk);
    op_valid  = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; op_valid = 1'b0; op_code = 2'd0; mem_rdata = 16'h8000;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 acc", acc, 16'h0000);
    chk("R1 flags", {wr_en, skip, par_err, ovf}, 16'h0);
    chk("R5 pzero after reset", {is_pzero, is_mzero}, 16'h2);
  endtask

  task automatic t_load();
    run_op(2'd0, 15'h0005);
    chk("R2 load +5", acc, 16'h0005);
    run_op(2'd0, 15'h7FFA);
    chk("R2 load -5 sign-extended", acc, 16'hFFFA);
  endtask

  task automatic t_add();
    run_op(2'd0, 15'h0005);
    run_op(2'd1, 15'h7FFC);
    chk("R3 5 + -3 end-around", acc, 16'h0002);
    run_op(2'd0, 15'h0001);
    run_op(2'd1, 15'h7FFE);
    chk("R3 1 + -1 gives minus zero", acc, 16'hFFFF);
    chk("R5 mzero flag", {is_pzero, is_mzero}, 16'h1);
    run_op(2'd1, 15'h7FFF);
    chk("R3 -0 + -0 stays -0", acc, 16'hFFFF);
  endtask

  task automatic t_neg();
    run_op(2'd0, 15'h0000);
    run_op(2'd2, 15'h0000);
    chk("R4 neg +0", acc, 16'hFFFF);
    run_op(2'd2, 15'h0000);
    chk("R4 neg -0", acc, 16'h0000);
    run_op(2'd0, 15'h0005);
    run_op(2'd2, 15'h0000);
    chk("R4 neg 5", acc, 16'hFFFA);
  endtask

  task automatic t_store_plain();
    run_op(2'd0, 15'h0005);
    run_op(2'd3, 15'h0000);
    chk("R7 store +5 word", {wr_en, wr_word[15:0]} == {1'b1, 16'h8005} ? 16'h1 : 16'h0, 16'h1);
    chk("R9 store no skip", {15'b0, skip}, 16'h0);
    chk("R9 acc kept", acc, 16'h0005);
    @(negedge clk);
    chk("R11 wr_en one cycle", {15'b0, wr_en}, 16'h0);
    run_op(2'd0, 15'h7FFF);
    run_op(2'd3, 15'h0000);
    chk("R7 store -0 word", wr_word, 16'h7FFF);
    chk("R9 -0 kept", acc, 16'hFFFF);
  endtask

  task automatic t_pos_ovf();
    run_op(2'd0, 15'h3FFF);
    run_op(2'd1, 15'h0001);
    chk("R6 positive overflow acc", acc, 16'h4000);
    chk("R6 ovf flag", {15'b0, ovf}, 16'h1);
    run_op(2'd3, 15'h0000);
    chk("R7 pos ovf store word", wr_word, 16'h8000);
    chk("R8 acc to +1", acc, 16'h0001);
    chk("R8 skip", {15'b0, skip}, 16'h1);
    @(negedge clk);
    chk("R8 skip one cycle", {15'b0, skip}, 16'h0);
  endtask

  task automatic t_neg_ovf();
    run_op(2'd0, 15'h4000);
    run_op(2'd1, 15'h7FFE);
    chk("R6 negative overflow acc", acc, 16'hBFFF);
    run_op(2'd3, 15'h0000);
    chk("R7 neg ovf store word", wr_word, 16'h7FFF);
    chk("R8 acc to -1", acc, 16'hFFFE);
    chk("R8 skip neg", {15'b0, skip}, 16'h1);
  endtask

  task automatic t_parity();
    do_reset();
    run_op(2'd0, 15'h0003);
    run_op(2'd2, 15'h0011, 1'b1);
    run_op(2'd3, 15'h0011, 1'b1);
    chk("R10 bad parity ignored on neg/store", {15'b0, par_err}, 16'h0);
    run_op(2'd1, 15'h0002, 1'b1);
    chk("R10 bad parity on add sets flag", {15'b0, par_err}, 16'h1);
    run_op(2'd0, 15'h0007);
    chk("R10 flag sticky", {15'b0, par_err}, 16'h1);
    do_reset();
    chk("R10 cleared by reset", {15'b0, par_err}, 16'h0);
  endtask

  task automatic t_idle();
    run_op(2'd0, 15'h0123);
    @(negedge clk);
    op_code = 2'd3; mem_rdata = 16'h0000;
    @(negedge clk);
    chk("R11 idle acc", acc, 16'h0123);
    chk("R11 idle no write/skip", {14'b0, wr_en, skip}, 16'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; op_valid = 1'b0; op_code = 2'd0; mem_rdata = 16'h8000;
    t_reset();
    t_load();
    t_add();
    t_neg();
    t_store_plain();
    t_pos_ovf();
    t_neg_ovf();
    t_parity();
    t_idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule